// File: doc/BRIEF.md
# Chained Scatter-Gather DMA Channel

This block is one channel of a DMA engine that moves words between a host address space and a local address space. Software programs it through a small register port. In direct mode the channel runs one transfer from its own registers. In chained mode it walks a linked list of descriptors held in memory. Each descriptor is four 32-bit words at a 16-byte aligned address: the host start address, the local start address, the byte count, and the link word. The low four bits of the link word are flags. Bit 0 set means the next descriptor lives in host space. Bit 1 marks the end of the chain. Bit 2 asks for an interrupt when this descriptor finishes. Bit 3 sets the direction to local-to-host (clear means host-to-local).

The channel has three ports toward the rest of the chip. A descriptor memory port with request/acknowledge reads descriptors and can write a byte count back. A data-mover port issues one request per word and waits for an acknowledge. Two interrupt lines go out, one toward the host side and one toward the local side. Bus protocols, FIFOs and width conversion sit outside the block.

Register select on `regAddr`: 0 host address, 1 local address, 2 byte count, 3 link word, 4 mode, 5 command/status. Mode bits: 9 chaining, 10 interrupt on the final descriptor, 11 hold local address, 16 zero the count word of each finished descriptor in memory, 17 route the interrupt to the host line. Command/status bits: 0 enable, 1 start, 2 abort, 3 clear interrupt, 4 done (read-only). Bits 1 to 3 act when written as 1 and read as 0.

Top module: `sgdma_channel`

## Requirements
- R1: After reset the status register reads 0x10 (done 1, enable 0), both interrupt lines are low and neither memory nor mover requests are raised.
- R2: Registers 0 to 4 read back what was written while the channel is idle. The byte count keeps only its low 23 bits and the mode keeps its low 18 bits. Writes to registers 0 to 4 are ignored while the channel is busy.
- R3: A status write with bits 0 and 1 both set starts the channel. A start written with bit 0 clear is ignored: done stays 1 and no mover request appears.
- R4: In direct mode (mode bit 9 clear) the channel issues ceil(count/4) mover requests. The host and local addresses start at the register values and advance by 4 per word. `moveDir` equals link-word bit 3. Done returns to 1 afterwards, and a zero count moves nothing.
- R5: With mode bit 11 set, the local address stays constant while the host address advances.
- R6: In chained mode the first descriptor is read from the link register address with bits 3:0 cleared. The four words are read at offsets 0, 4, 8 and 12 and loaded into host address, local address, count and link word. `memHostSpace` carries bit 0 of the link word that pointed to the descriptor.
- R7: After a descriptor's words are moved, the channel fetches the next descriptor unless link bit 1 is set, in which case done returns to 1.
- R8: In chained mode with mode bit 16 set, each finished descriptor has the value 0 written to its offset 8. With mode bit 16 clear, nothing is written to memory.
- R9: The interrupt flag is set when a descriptor with link bit 2 finishes, or when the final descriptor finishes with mode bit 10 set. It stays set until a status write with bit 3; a set and a clear in the same cycle leave it set.
- R10: The interrupt flag drives `irqHost` when mode bit 17 is 1 and `irqLocal` when it is 0.
- R11: A status write with bit 2 set while busy stops the channel on that edge. Done reads 1 and no further mover request appears; because the write carries bit 0 clear, enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| memReq | output | 1 | Descriptor memory request |
| memWe | output | 1 | Descriptor memory write (count write-back) |
| memAddr | output | 32 | Descriptor memory byte address |
| memHostSpace | output | 1 | Descriptor lies in host space |
| memWData | output | 32 | Descriptor memory write data |
| memAck | input | 1 | Descriptor memory acknowledge; read data valid with it |
| memRData | input | 32 | Descriptor memory read data |
| moveReq | output | 1 | Data mover word request |
| moveDir | output | 1 | 1 local-to-host, 0 host-to-local |
| moveHostAddr | output | 32 | Host byte address of the current word |
| moveLocalAddr | output | 32 | Local byte address of the current word |
| moveAck | input | 1 | Data mover word acknowledge |
| irqHost | output | 1 | Interrupt toward the host side |
| irqLocal | output | 1 | Interrupt toward the local side |

## Verification
The bench builds the channel with its default parameters: a 23-bit count and 4-byte words. With these, odd byte counts that round up to a whole word, zero-length transfers and the truncation of an oversized count are all reachable in a short run. A two-descriptor chain that crosses from local to host space exercises fetch order, count write-back and the terminal-count interrupt. An abort partway through a 100-word transfer leaves enough time to show that register writes are refused while busy.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int DATA_W = 32;
  localparam int MODE_W = 18;

  // register select codes
  localparam logic [2:0] SEL_HOST  = 3'd0;
  localparam logic [2:0] SEL_LOCAL = 3'd1;
  localparam logic [2:0] SEL_COUNT = 3'd2;
  localparam logic [2:0] SEL_LINK  = 3'd3;
  localparam logic [2:0] SEL_MODE  = 3'd4;
  localparam logic [2:0] SEL_CSR   = 3'd5;

  // mode bit positions
  localparam int M_CHAIN   = 9;
  localparam int M_LASTIRQ = 10;
  localparam int M_HOLDLOC = 11;
  localparam int M_ZEROCNT = 16;
  localparam int M_HOSTIRQ = 17;

  // command/status bit positions
  localparam int C_ENABLE = 0;
  localparam int C_START  = 1;
  localparam int C_ABORT  = 2;
  localparam int C_CLRIRQ = 3;
  localparam int C_DONE   = 4;

  // link word flag positions
  localparam int L_HOSTSPACE = 0;
  localparam int L_END       = 1;
  localparam int L_TCIRQ     = 2;
  localparam int L_TOHOST    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MOVE,
    ST_WBACK,
    ST_STEP
  } chanState_t;

  typedef struct packed {
    logic       pointNext;   // latch descriptor pointer from link word
    logic       loadWord;    // load fetched descriptor word
    logic [1:0] wordIdx;     // which descriptor word
    logic       stepBeat;    // one word moved
    logic       raiseIrq;    // set interrupt flag
  } ctrlStrobes_t;

endpackage

// File: rtl/sgdma_dpath.sv
module sgdma_dpath
  import sgdma_pkg::*;
#(
  parameter int SIZE_W     = 23,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busy,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] hostAddr,
  output logic [DATA_W-1:0] localAddr,
  output logic [DATA_W-1:0] linkWord,
  output logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] curDesc,
  output logic              curHostSpace,
  output logic              sizeZero,
  output logic              intFlag
);

  localparam logic [SIZE_W-1:0] STEP_BYTES = SIZE_W'(WORD_BYTES);

  logic [SIZE_W-1:0] remain;
  logic              enable;
  logic              csrWr, clrCmd, swWr;

  assign csrWr  = regWrEn && (regAddr == SEL_CSR);
  assign clrCmd = csrWr && regWrData[C_CLRIRQ];
  assign swWr   = regWrEn && !busy;
  assign sizeZero = (remain == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostAddr     <= '0;
      localAddr    <= '0;
      remain       <= '0;
      linkWord     <= '0;
      mode         <= '0;
      enable       <= 1'b0;
      intFlag      <= 1'b0;
      curDesc      <= '0;
      curHostSpace <= 1'b0;
    end else begin
      if (swWr) begin
        case (regAddr)
          SEL_HOST:  hostAddr  <= regWrData;
          SEL_LOCAL: localAddr <= regWrData;
          SEL_COUNT: remain    <= regWrData[SIZE_W-1:0];
          SEL_LINK:  linkWord  <= regWrData;
          SEL_MODE:  mode      <= regWrData[MODE_W-1:0];
          default: ;
        endcase
      end
      if (csrWr) enable <= regWrData[C_ENABLE];

      if (strb.loadWord) begin
        case (strb.wordIdx)
          2'd0: hostAddr  <= memRData;
          2'd1: localAddr <= memRData;
          2'd2: remain    <= memRData[SIZE_W-1:0];
          default: linkWord <= memRData;
        endcase
      end

      if (strb.stepBeat) begin
        remain   <= (remain > STEP_BYTES) ? remain - STEP_BYTES : '0;
        hostAddr <= hostAddr + DATA_W'(WORD_BYTES);
        if (!mode[M_HOLDLOC]) localAddr <= localAddr + DATA_W'(WORD_BYTES);
      end

      if (strb.pointNext) begin
        curDesc      <= {linkWord[DATA_W-1:4], 4'b0000};
        curHostSpace <= linkWord[L_HOSTSPACE];
      end

      // set has priority over a same-cycle clear
      if (strb.raiseIrq)    intFlag <= 1'b1;
      else if (clrCmd)      intFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      SEL_HOST:  regRdData = hostAddr;
      SEL_LOCAL: regRdData = localAddr;
      SEL_COUNT: regRdData = DATA_W'(remain);
      SEL_LINK:  regRdData = linkWord;
      SEL_MODE:  regRdData = DATA_W'(mode);
      SEL_CSR: begin
        regRdData           = '0;
        regRdData[C_ENABLE] = enable;
        regRdData[C_DONE]   = !busy;
      end
      default:   regRdData = '0;
    endcase
  end

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    intFlag && !clrCmd |=> intFlag);

  assert_irq_from_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> $past(busy));

  assert_count_shrinks_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepBeat |=> remain < $past(remain));

  assert_local_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepBeat && mode[M_HOLDLOC] |=> $stable(localAddr));

  assert_no_sw_write_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strb.stepBeat && !strb.loadWord && !strb.pointNext |=> $stable(mode) && $stable(linkWord));

endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
  import sgdma_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startCmd,
  input  logic         abortCmd,
  input  logic         chainEn,
  input  logic         zeroCntEn,
  input  logic         lastIrqEn,
  input  logic         endFlag,
  input  logic         tcFlag,
  input  logic         sizeZero,
  input  logic         memAck,
  input  logic         moveAck,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         memReq,
  output logic         memWe,
  output logic [1:0]   memWordSel,
  output logic         moveReq
);

  chanState_t   state, stateNext;
  logic [1:0]   idx, idxNext;
  ctrlStrobes_t strbRaw;
  logic         lastDesc;

  assign busy     = (state != ST_IDLE);
  assign lastDesc = !chainEn || endFlag;

  always_comb begin
    stateNext  = state;
    idxNext    = idx;
    strbRaw    = '0;
    memReq     = 1'b0;
    memWe      = 1'b0;
    memWordSel = idx;
    moveReq    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startCmd && !abortCmd) begin
          idxNext = 2'd0;
          if (chainEn) begin
            strbRaw.pointNext = 1'b1;
            stateNext = ST_FETCH;
          end else begin
            stateNext = ST_MOVE;
          end
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strbRaw.loadWord = 1'b1;
          strbRaw.wordIdx  = idx;
          idxNext = idx + 2'd1;
          if (idx == 2'd3) stateNext = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (sizeZero) begin
          stateNext = (chainEn && zeroCntEn) ? ST_WBACK : ST_STEP;
        end else begin
          moveReq = 1'b1;
          if (moveAck) strbRaw.stepBeat = 1'b1;
        end
      end
      ST_WBACK: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        memWordSel = 2'd2;
        if (memAck) stateNext = ST_STEP;
      end
      ST_STEP: begin
        strbRaw.raiseIrq = tcFlag || (lastDesc && lastIrqEn);
        if (lastDesc) begin
          stateNext = ST_IDLE;
        end else begin
          strbRaw.pointNext = 1'b1;
          idxNext   = 2'd0;
          stateNext = ST_FETCH;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (abortCmd && busy) begin
      stateNext = ST_IDLE;
      strbRaw   = '0;
    end
  end

  assign strb = strbRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= 2'd0;
    end else begin
      state <= stateNext;
      idx   <= idxNext;
    end
  end

  assert_quiet_when_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !moveReq);

  assert_move_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    moveReq && !moveAck && !abortCmd |=> moveReq);

  assert_abort_stops_R11: assert property (@(posedge clk) disable iff (!rstN)
    abortCmd && busy |=> !busy);

  assert_fetch_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !abortCmd |=> memReq && $stable(memWordSel));

endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel
  import sgdma_pkg::*;
#(
  parameter int SIZE_W     = 23,
  parameter int WORD_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic        memHostSpace,
  output logic [31:0] memWData,
  input  logic        memAck,
  input  logic [31:0] memRData,
  output logic        moveReq,
  output logic        moveDir,
  output logic [31:0] moveHostAddr,
  output logic [31:0] moveLocalAddr,
  input  logic        moveAck,
  output logic        irqHost,
  output logic        irqLocal
);

  ctrlStrobes_t      strb;
  logic              busy, sizeZero, intFlag, curHostSpace;
  logic              csrWr, startCmd, abortCmd;
  logic [1:0]        memWordSel;
  logic [DATA_W-1:0] hostAddr, localAddr, linkWord, curDesc;
  logic [MODE_W-1:0] mode;

  assign csrWr    = regWrEn && (regAddr == SEL_CSR);
  assign startCmd = csrWr && regWrData[C_START] && regWrData[C_ENABLE];
  assign abortCmd = csrWr && regWrData[C_ABORT];

  sgdma_dpath #(.SIZE_W(SIZE_W), .WORD_BYTES(WORD_BYTES)) dpath (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .busy(busy), .strb(strb), .memRData(memRData),
    .regRdData(regRdData),
    .hostAddr(hostAddr), .localAddr(localAddr), .linkWord(linkWord),
    .mode(mode), .curDesc(curDesc), .curHostSpace(curHostSpace),
    .sizeZero(sizeZero), .intFlag(intFlag)
  );

  sgdma_ctrl ctrl (
    .clk(clk), .rstN(rstN),
    .startCmd(startCmd), .abortCmd(abortCmd),
    .chainEn(mode[M_CHAIN]), .zeroCntEn(mode[M_ZEROCNT]),
    .lastIrqEn(mode[M_LASTIRQ]),
    .endFlag(linkWord[L_END]), .tcFlag(linkWord[L_TCIRQ]),
    .sizeZero(sizeZero), .memAck(memAck), .moveAck(moveAck),
    .strb(strb), .busy(busy),
    .memReq(memReq), .memWe(memWe), .memWordSel(memWordSel),
    .moveReq(moveReq)
  );

  assign memAddr       = {curDesc[DATA_W-1:4], memWordSel, 2'b00};
  assign memHostSpace  = curHostSpace;
  assign memWData      = '0;
  assign moveDir       = linkWord[L_TOHOST];
  assign moveHostAddr  = hostAddr;
  assign moveLocalAddr = localAddr;
  assign irqHost       = intFlag && mode[M_HOSTIRQ];
  assign irqLocal      = intFlag && !mode[M_HOSTIRQ];

  assert_wback_count_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq && (memAddr[3:0] == 4'h8) && (memWData == '0));

  assert_irq_one_line_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqHost, irqLocal}));

endmodule

// File: tb/sgdma_channel_test.sv
`timescale 1ns/1ps
module sgdma_channel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd5;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe, memHostSpace, memAck;
  logic [31:0] memAddr, memWData, memRData;
  logic        moveReq, moveDir, moveAck;
  logic [31:0] moveHostAddr, moveLocalAddr;
  logic        irqHost, irqLocal;

  always #2.5 clk = ~clk;

  sgdma_channel uut (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memHostSpace(memHostSpace),
    .memWData(memWData), .memAck(memAck), .memRData(memRData),
    .moveReq(moveReq), .moveDir(moveDir), .moveHostAddr(moveHostAddr),
    .moveLocalAddr(moveLocalAddr), .moveAck(moveAck),
    .irqHost(irqHost), .irqLocal(irqLocal)
  );

  int total = 0;
  int fails = 0;
  logic [31:0] mem [64];
  int beats = 0, wbCount = 0, hostFetches = 0;
  logic [31:0] lastH = '0, lastL = '0;
  logic lastDir = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      memAck  <= 1'b0;
      moveAck <= 1'b0;
    end else begin
      memAck   <= memReq && !memAck;
      moveAck  <= moveReq && !moveAck;
      memRData <= mem[memAddr[7:2]];
      if (memReq && memAck && memWe) begin
        mem[memAddr[7:2]] <= memWData;
        wbCount <= wbCount + 1;
      end
      if (memReq && memAck && !memWe && memHostSpace) hostFetches <= hostFetches + 1;
      if (moveReq && moveAck) begin
        beats   <= beats + 1;
        lastH   <= moveHostAddr;
        lastL   <= moveLocalAddr;
        lastDir <= moveDir;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd5;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5 d = regRdData;
    regAddr = 3'd5;
  endtask

  task automatic waitDone();
    int n = 0;
    regAddr = 3'd5;
    while (regRdData[4] !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check(1'b0, "R4", "timeout waiting for done", 0, 1);
  endtask

  task automatic clearLog();
    @(negedge clk);
    beats = 0; wbCount = 0; hostFetches = 0; lastH = '0; lastL = '0; lastDir = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] h;
    logic [31:0] l;
    logic [31:0] sz;
    logic        dir;
    logic        hold;
    logic [7:0]  words;
    logic [31:0] lastHostExp;
    logic [31:0] lastLocalExp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h1000, 32'h2000, 32'd16, 1'b0, 1'b0, 8'd4, 32'h100C, 32'h200C},
    '{32'h3000, 32'h0400, 32'd5,  1'b1, 1'b0, 8'd2, 32'h3004, 32'h0404},
    '{32'h0010, 32'h0080, 32'd12, 1'b1, 1'b1, 8'd3, 32'h0018, 32'h0080},
    '{32'h0900, 32'h0A00, 32'd0,  1'b0, 1'b0, 8'd0, 32'h0000, 32'h0000},
    '{32'h0500, 32'h0600, 32'd4,  1'b0, 1'b0, 8'd1, 32'h0500, 32'h0600}
  };

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int saved;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(3'd5, d);
    check(d == 32'h10, "R1", "status after reset", d, 32'h10);
    check(!irqHost && !irqLocal, "R1", "irq lines after reset", {irqHost, irqLocal}, 0);
    check(!memReq && !moveReq, "R1", "requests after reset", {memReq, moveReq}, 0);

    // R2 register access and truncation
    writeReg(3'd0, 32'h12345678);
    readReg(3'd0, d);
    check(d == 32'h12345678, "R2", "host address readback", d, 32'h12345678);
    writeReg(3'd2, 32'hFFFFFFFF);
    readReg(3'd2, d);
    check(d == 32'h007FFFFF, "R2", "count truncated to 23 bits", d, 32'h007FFFFF);
    writeReg(3'd4, 32'hFFFFFFFF);
    readReg(3'd4, d);
    check(d == 32'h0003FFFF, "R2", "mode truncated to 18 bits", d, 32'h0003FFFF);

    // R4/R5 vector table, direct mode
    foreach (VECS[i]) begin
      writeReg(3'd0, VECS[i].h);
      writeReg(3'd1, VECS[i].l);
      writeReg(3'd2, VECS[i].sz);
      writeReg(3'd3, {28'd0, VECS[i].dir, 3'b000});
      writeReg(3'd4, VECS[i].hold ? 32'h800 : 32'h0);
      clearLog();
      writeReg(3'd5, 32'h3);
      waitDone();
      @(negedge clk);
      check(beats == int'(VECS[i].words), "R4", $sformatf("vector %0d word count", i), beats, VECS[i].words);
      check(lastH == VECS[i].lastHostExp, "R4", $sformatf("vector %0d last host address", i), lastH, VECS[i].lastHostExp);
      check(lastL == VECS[i].lastLocalExp, VECS[i].hold ? "R5" : "R4",
            $sformatf("vector %0d last local address", i), lastL, VECS[i].lastLocalExp);
      check(lastDir == VECS[i].dir || VECS[i].words == 0, "R4", $sformatf("vector %0d direction", i), lastDir, VECS[i].dir);
    end
    check(!irqHost && !irqLocal, "R9", "no interrupt without flag or mode bit", {irqHost, irqLocal}, 0);

    // R3 start without enable is ignored
    writeReg(3'd2, 32'd8);
    clearLog();
    writeReg(3'd5, 32'h2);
    repeat (6) @(negedge clk);
    readReg(3'd5, d);
    check(d == 32'h10, "R3", "status after start without enable", d, 32'h10);
    check(beats == 0, "R3", "no words moved without enable", beats, 0);

    // R6/R7/R8/R9 two-descriptor chain, count write-back, tc interrupt
    mem[16] = 32'h100; mem[17] = 32'h200; mem[18] = 32'd8; mem[19] = 32'h81;
    mem[32] = 32'h300; mem[33] = 32'h400; mem[34] = 32'd4; mem[35] = 32'h6;
    writeReg(3'd3, 32'h40);
    writeReg(3'd4, 32'h10200);
    clearLog();
    writeReg(3'd5, 32'h3);
    waitDone();
    @(negedge clk);
    check(beats == 3, "R7", "words moved across chain", beats, 3);
    check(lastH == 32'h300, "R6", "host address from second descriptor", lastH, 32'h300);
    check(lastL == 32'h400, "R6", "local address from second descriptor", lastL, 32'h400);
    check(hostFetches == 4, "R6", "host-space descriptor reads", hostFetches, 4);
    check(wbCount == 2, "R8", "count write-backs", wbCount, 2);
    check(mem[18] == 0 && mem[34] == 0, "R8", "count words zeroed", mem[18] | mem[34], 0);
    check(irqLocal && !irqHost, "R9", "terminal-count interrupt on local line", {irqHost, irqLocal}, 2'b01);

    // R9 clear
    writeReg(3'd5, 32'h8);
    check(!irqLocal && !irqHost, "R9", "interrupt cleared", {irqHost, irqLocal}, 0);

    // R9/R10/R8 final-descriptor interrupt routed to host, no write-back
    mem[48] = 32'h700; mem[49] = 32'h800; mem[50] = 32'd4; mem[51] = 32'h2;
    writeReg(3'd3, 32'hC0);
    writeReg(3'd4, 32'h20600);
    clearLog();
    writeReg(3'd5, 32'h3);
    waitDone();
    @(negedge clk);
    check(beats == 1, "R7", "single-descriptor chain words", beats, 1);
    check(irqHost && !irqLocal, "R10", "interrupt routed to host line", {irqHost, irqLocal}, 2'b10);
    check(mem[50] == 32'd4 && wbCount == 0, "R8", "no write-back without mode bit", mem[50], 4);
    writeReg(3'd5, 32'h8);

    // R11 abort, R2 writes ignored while busy
    writeReg(3'd0, 32'h1000);
    writeReg(3'd1, 32'h2000);
    writeReg(3'd2, 32'd400);
    writeReg(3'd3, 32'h0);
    writeReg(3'd4, 32'h0);
    clearLog();
    writeReg(3'd5, 32'h3);
    repeat (6) @(negedge clk);
    writeReg(3'd4, 32'h200);
    writeReg(3'd5, 32'h4);
    #0.5;
    check(regRdData == 32'h10, "R11", "status after abort", regRdData, 32'h10);
    check(!moveReq, "R11", "mover request dropped", moveReq, 0);
    saved = beats;
    repeat (5) @(negedge clk);
    check(beats == saved && beats < 100, "R11", "no words after abort", beats, saved);
    readReg(3'd4, d);
    check(d == 32'h0, "R2", "mode write ignored while busy", d, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule